// File: doc/BRIEF.md
# External Sample Trigger Qualifier

This block lets one shared interrupt pin work as a trigger input for synchronized sampling. While the sync-sampling enable is low, the pin is an ordinary interrupt output driven from the interrupt request. While the enable is high, the pin's driver is released and the pin level is read instead. The level passes through a two-flop synchronizer. Each active-high pulse is then measured in clock cycles against three minimums: the time spent low before the rise, the time spent high, and the spacing since the last accepted trigger. Only then does the block issue a single-cycle sample-start strobe.

A pulse that breaks any of these limits produces no strobe and sets a sticky error flag, which stays set until a write clears it. A second shared pin has its own enable that turns it into an external clock input. The two alternate functions are independent and may be active alone or together. The block only releases or drives that second pin and does not use the clock itself. Each minimum is given in nanoseconds together with the clock frequency, and is converted to a whole number of cycles. The defaults are 25 us for the high time, 25 us for the low time and 1.6 ms for the spacing, at a 250 MHz clock.

Top module: `ext_trig_qual`

## Requirements
- R1: With `sync_en_i` = 0, `pin_oe_o` = 1 and `pin_do_o` equals `irq_i`, and `sample_o` never asserts, even for a pulse on `trig_pin_i` that would otherwise qualify.
- R2: With `sync_en_i` = 1, `pin_oe_o` = 0 and `pin_do_o` = 0 whatever the value of `irq_i`.
- R3: The second pin is controlled only by `clk_en_i`. With `clk_en_i` = 1, `pin2_oe_o` = 0 and `pin2_do_o` = 0. With `clk_en_i` = 0, `pin2_oe_o` = 1 and `pin2_do_o` = `irq2_i`. This holds for any value of `sync_en_i`.
- R4: For an accepted pulse, let edge m be the first clock edge that samples `trig_pin_i` low after the pulse. `sample_o` is then high for exactly one cycle, between edges m+2 and m+3.
- R5: A pulse is accepted only if it is sampled high on at least HI_CYC consecutive edges, where HI_CYC = ceil(CLK_FREQ_KHZ * MIN_HIGH_NS / 1e6). A shorter pulse gives no strobe and sets `err_o`.
- R6: A rise that follows fewer than LO_CYC low samples (computed in the same way from MIN_LOW_NS) is rejected. That pulse gives no strobe and sets `err_o`.
- R7: Let S be the number of edges between the falling edge of the last accepted pulse and the falling edge of a new pulse. The new pulse is rejected, with `err_o` set and no strobe, when S < PER_CYC (computed from MIN_PERIOD_NS), and is accepted when S >= PER_CYC. A rejected pulse does not restart this spacing.
- R8: `err_o` is sticky and is cleared by `err_clr_i`. When an error and a clear occur on the same edge, the error wins and `err_o` stays 1.
- R9: A pulse that is already high when `sync_en_i` rises is ignored when it falls: it gives no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_en_i | input | 1 | Sync-sampling enable; makes the first pin a trigger input |
| clk_en_i | input | 1 | External-clock enable; makes the second pin an input |
| trig_pin_i | input | 1 | Raw, asynchronous level of the first pin |
| irq_i | input | 1 | Interrupt request meant for the first pin |
| irq2_i | input | 1 | Interrupt request meant for the second pin |
| err_clr_i | input | 1 | Write strobe that clears the error flag |
| sample_o | output | 1 | One-cycle sample-start strobe |
| pin_oe_o | output | 1 | Output enable of the first pin |
| pin_do_o | output | 1 | Output value of the first pin |
| pin2_oe_o | output | 1 | Output enable of the second pin |
| pin2_do_o | output | 1 | Output value of the second pin |
| err_o | output | 1 | Sticky flag for a rejected trigger pulse |

## Verification
A trigger rejection and a software clear of the error flag can land on the same clock edge. The bench provokes this in two steps. First a short pulse leaves `err_o` set. Then `err_clr_i` is held high over the edge that samples the end of a second short pulse and the two edges before it. `err_o` must read 0 after the earlier clearing edges and 1 after the rejection edge, which shows that the set takes priority over the clear. The same bench also places accepted and rejected pulses at the exact high-time, low-time and spacing boundaries, so that strobe and error are each judged in the cycle where they must appear.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // ceil(khz * ns / 1e6) clock cycles
  function automatic int unsigned ns_to_cyc(input longint unsigned khz, input longint unsigned ns);
    longint unsigned prod;
    prod = (khz * ns + 64'd999_999) / 64'd1_000_000;
    return int'(prod);
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/trig_cnt.sv
module trig_cnt #(
  parameter int unsigned MAX      = 8,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic inc_i,
  output logic full_o
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] CMAX = W'(MAX);
  localparam logic [W-1:0] CRST = RST_FULL ? CMAX : '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= CRST;
    else if (ld_i)                  cnt_q <= W'(1);
    else if (inc_i && cnt_q != CMAX) cnt_q <= cnt_q + W'(1);
  end

  assign full_o = (cnt_q == CMAX);
endmodule

// File: rtl/trig_pin_mux.sv
module trig_pin_mux (
  input  logic alt_en_i,
  input  logic irq_i,
  output logic oe_o,
  output logic do_o
);
  assign oe_o = ~alt_en_i;
  assign do_o = alt_en_i ? 1'b0 : irq_i;
endmodule

// File: rtl/ext_trig_qual.sv
module ext_trig_qual #(
  parameter int unsigned CLK_FREQ_KHZ  = 250_000,
  parameter int unsigned MIN_HIGH_NS   = 25_000,
  parameter int unsigned MIN_LOW_NS    = 25_000,
  parameter int unsigned MIN_PERIOD_NS = 1_600_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  input  logic clk_en_i,
  input  logic trig_pin_i,
  input  logic irq_i,
  input  logic irq2_i,
  input  logic err_clr_i,
  output logic sample_o,
  output logic pin_oe_o,
  output logic pin_do_o,
  output logic pin2_oe_o,
  output logic pin2_do_o,
  output logic err_o
);
  localparam int unsigned HI_CYC  = trig_pkg::ns_to_cyc(CLK_FREQ_KHZ, MIN_HIGH_NS);
  localparam int unsigned LO_CYC  = trig_pkg::ns_to_cyc(CLK_FREQ_KHZ, MIN_LOW_NS);
  localparam int unsigned PER_CYC = trig_pkg::ns_to_cyc(CLK_FREQ_KHZ, MIN_PERIOD_NS);

  logic lvl, prev_q, rise, fall;
  logic hi_full, lo_full, gap_full;
  logic armed_q, accept, reject;
  logic sample_q, err_q;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trig_pin_i), .q_o(lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  trig_cnt #(.MAX(HI_CYC), .RST_FULL(1'b0)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(rise), .inc_i(lvl & prev_q), .full_o(hi_full)
  );

  trig_cnt #(.MAX(LO_CYC), .RST_FULL(1'b1)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(fall), .inc_i(~lvl & ~prev_q), .full_o(lo_full)
  );

  // spacing runs from the fall of the last accepted pulse
  trig_cnt #(.MAX(PER_CYC), .RST_FULL(1'b1)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(accept), .inc_i(1'b1), .full_o(gap_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (!sync_en_i) armed_q <= 1'b0;
    else if (rise)       armed_q <= lo_full;
    else if (fall)       armed_q <= 1'b0;
  end

  assign accept = sync_en_i & armed_q & fall & hi_full & gap_full;
  assign reject = sync_en_i & ((rise & ~lo_full) |
                               (fall & armed_q & ~(hi_full & gap_full)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      sample_q <= accept;
      if (reject)         err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign sample_o = sample_q;
  assign err_o    = err_q;

  trig_pin_mux u_mux_trig (
    .alt_en_i(sync_en_i), .irq_i(irq_i), .oe_o(pin_oe_o), .do_o(pin_do_o)
  );

  trig_pin_mux u_mux_clk (
    .alt_en_i(clk_en_i), .irq_i(irq2_i), .oe_o(pin2_oe_o), .do_o(pin2_do_o)
  );
endmodule

// File: rtl/trig_qual_chk.sv
module trig_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_en_i,
  input logic clk_en_i,
  input logic trig_pin_i,
  input logic irq_i,
  input logic irq2_i,
  input logic err_clr_i,
  input logic sample_o,
  input logic pin_oe_o,
  input logic pin_do_o,
  input logic pin2_oe_o,
  input logic pin2_do_o,
  input logic err_o
);
  AST_OUT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_en_i |-> (pin_oe_o && pin_do_o == irq_i)); // R1

  AST_NO_STB_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(sync_en_i)); // R1

  AST_IN_WHEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_i |-> (!pin_oe_o && !pin_do_o)); // R2

  AST_PIN2_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i ? (!pin2_oe_o && !pin2_do_o) : (pin2_oe_o && pin2_do_o == irq2_i)); // R3

  AST_STB_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R4

  AST_STB_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (!$past(trig_pin_i, 3) && $past(trig_pin_i, 4))); // R4

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o); // R8

  AST_ERR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(sync_en_i)); // R9
endmodule

bind ext_trig_qual trig_qual_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_en_i(sync_en_i), .clk_en_i(clk_en_i),
  .trig_pin_i(trig_pin_i), .irq_i(irq_i), .irq2_i(irq2_i), .err_clr_i(err_clr_i),
  .sample_o(sample_o), .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o),
  .pin2_oe_o(pin2_oe_o), .pin2_do_o(pin2_do_o), .err_o(err_o)
);

// File: tb/sim_ext_trig_qual.sv
module sim_ext_trig_qual;
  // HI_CYC = LO_CYC = 8, PER_CYC = 40
  localparam int WIN = 6;
  // {low cycles after window, high cycles, expect strobe, expect error}
  localparam int VEC [10][4] = '{
    '{40,   8, 1, 0},  // R5 high exactly at minimum
    '{40,   7, 0, 1},  // R5 high one short
    '{ 1,  40, 0, 1},  // R6 low 7 samples
    '{ 2,  40, 1, 0},  // R6 low 8 samples
    '{ 2,  31, 0, 1},  // R7 spacing 39
    '{30,  20, 1, 0},
    '{ 2,  32, 1, 0},  // R7 spacing 40
    '{10,  10, 0, 1},  // R7 spacing 26
    '{30, 100, 1, 0},
    '{40,  12, 1, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_en = 1'b1, clk_en = 1'b0, pin = 1'b0, irq = 1'b0, irq2 = 1'b0, clr = 1'b0;
  logic sample, oe, dout, oe2, dout2, err;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_trig_qual #(
    .CLK_FREQ_KHZ(1000), .MIN_HIGH_NS(8000), .MIN_LOW_NS(8000), .MIN_PERIOD_NS(40000)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_en_i(sync_en), .clk_en_i(clk_en),
    .trig_pin_i(pin), .irq_i(irq), .irq2_i(irq2), .err_clr_i(clr),
    .sample_o(sample), .pin_oe_o(oe), .pin_do_o(dout),
    .pin2_oe_o(oe2), .pin2_do_o(dout2), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int lo, input int hi, input int es, input int ee);
    int nstb = 0, pos = 0, errv = 0;
    repeat (lo) @(negedge clk);
    pin = 1'b1;
    repeat (hi) @(negedge clk);
    pin = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (sample) begin nstb++; pos = k; end
      if (k == 4) errv = int'(err);
      if (k == 5) clr = 1'b1;
      if (k == WIN) clr = 1'b0;
    end
    chk(nstb == es, "R5/R6/R7 strobe count", nstb, es);
    if (es != 0) chk(pos == 3, "R4 strobe cycle", pos, 3);
    chk(errv == ee, "R5/R6/R7 error", errv, ee);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sample == 1'b0, "reset sample", int'(sample), 0);
    chk(err == 1'b0, "reset err", int'(err), 0);
    chk(oe == 1'b0, "R2 reset oe", int'(oe), 0);
    repeat (40) @(negedge clk);

    for (int i = 0; i < 10; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // R2: pin released, interrupt blocked
    irq = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0 && dout == 1'b0, "R2 pin released", {30'd0, oe, dout}, 0);

    // R8: set and clear on the same edge
    repeat (20) @(negedge clk);
    pin = 1'b1; repeat (3) @(negedge clk); pin = 1'b0;
    repeat (WIN) @(negedge clk);
    chk(err == 1'b1, "R8 err from short pulse", int'(err), 1);
    repeat (20) @(negedge clk);
    pin = 1'b1; repeat (3) @(negedge clk);
    pin = 1'b0; clr = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R8 clear", int'(err), 0);
    @(negedge clk);
    @(negedge clk);
    chk(err == 1'b1, "R8 set beats clear", int'(err), 1);
    clr = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R8 sticky", int'(err), 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(err == 1'b0, "R8 cleared by write", int'(err), 0);

    // R9: pulse already high when enabled
    repeat (50) @(negedge clk);
    sync_en = 1'b0;
    pin = 1'b1; repeat (12) @(negedge clk);
    sync_en = 1'b1; repeat (12) @(negedge clk);
    pin = 1'b0;
    begin
      int n9 = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (sample) n9++; end
      chk(n9 == 0, "R9 no strobe", n9, 0);
      chk(err == 1'b0, "R9 no error", int'(err), 0);
    end

    // R1: disabled, valid pulse ignored, irq driven
    repeat (50) @(negedge clk);
    sync_en = 1'b0; irq = 1'b1;
    @(negedge clk);
    chk(oe == 1'b1 && dout == 1'b1, "R1 drive irq high", {30'd0, oe, dout}, 3);
    irq = 1'b0;
    @(negedge clk);
    chk(oe == 1'b1 && dout == 1'b0, "R1 drive irq low", {30'd0, oe, dout}, 2);
    begin
      int n1 = 0;
      pin = 1'b1;
      for (int k = 0; k < 12; k++) begin @(negedge clk); if (sample) n1++; end
      pin = 1'b0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); if (sample) n1++; end
      chk(n1 == 0, "R1 no strobe when disabled", n1, 0);
      chk(err == 1'b0, "R1 no error when disabled", int'(err), 0);
    end

    // R3: second pin independent of first
    irq2 = 1'b1; clk_en = 1'b1;
    @(negedge clk);
    chk(oe2 == 1'b0 && dout2 == 1'b0, "R3 pin2 input", {30'd0, oe2, dout2}, 0);
    sync_en = 1'b1; clk_en = 1'b0;
    @(negedge clk);
    chk(oe2 == 1'b1 && dout2 == 1'b1, "R3 pin2 irq", {30'd0, oe2, dout2}, 3);
    chk(oe == 1'b0, "R3 pin1 unaffected", int'(oe), 0);
    clk_en = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0 && oe2 == 1'b0, "R3 both inputs", {30'd0, oe, oe2}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule